// File: doc/BRIEF.md
# Prioritised Interrupt Request Unit

This block arbitrates the hardware interrupt requests of a small processor core and produces the call address that the core jumps to. It has four request inputs. One of them cannot be masked and has the highest priority. It is only accepted when it has risen and is still high one sample later. The other three are maskable lines with a fixed priority. The top line holds a rising edge until that edge is serviced. The two lower lines follow their input level. The block also turns a software restart number into its fixed restart address, using eight-byte slots.

The core issues commands to the block as single-cycle strobes. Enable and disable commands control a global interrupt-enable flag. A mask-write command loads the per-line mask bits and can also discard a held edge. A status-read command captures the mask, enable and pending state into a status register. When a request is accepted, the block raises a one-cycle taken pulse together with a 16-bit vector. The core does the stack push and the program-counter load itself. Accepting any hardware request clears the enable flag.

Top module: `irq_prio_unit`

## Requirements
- R1: After reset, take_q is low, the enable flag is clear and all three mask bits are set, so a status read returns 8'h07.
- R2: The non-maskable input is accepted only if it was low, is then sampled high, and is sampled high again at the next edge. take_q and vector 16'h0024 appear after that second edge, whatever the enable flag and masks hold. A request that is high for only one sample is never accepted, and a level that stays high is accepted only once.
- R3: If the non-maskable input and a maskable line are both acceptable at the same edge, the non-maskable one is taken.
- R4: Maskable lines are line_req[2] (top), line_req[1] (middle) and line_req[0] (bottom), in that priority order. Their vectors are 16'h003C, 16'h0034 and 16'h002C.
- R5: A maskable line is never accepted while the enable flag is clear or while its mask bit (mask_wdata bit index = line index, 1 = masked) is set.
- R6: cmd_ie_set sets the enable flag and cmd_ie_clr clears it. The new value governs acceptance from the following edge onward. cmd_ie_clr wins if both are strobed together.
- R7: Accepting any hardware request clears the enable flag. A maskable line that stays high is therefore not accepted a second time until the flag is set again.
- R8: The top line records a rising edge even while it is masked or disabled. It holds that edge until the edge is serviced or discarded by a mask write with mask_clr_edges high.
- R9: The middle and bottom lines are level sensitive. A level removed before it is accepted leaves no trace.
- R10: A mask write takes effect from the edge after the write. Acceptance at the edge of the write still uses the old mask.
- R11: A status read loads status_q at that edge with the values held just before it. The fields are bits [2:0] masks, bit 3 enable flag, bits [6:4] raw pending (top-line edge latch, middle level, bottom level in bits 6, 5, 4) and bit 7 non-maskable input level.
- R12: sw_rst_req with number n gives take_q and vector n*8, and leaves the enable flag unchanged. A hardware acceptance at the same edge takes precedence, and the restart request is dropped.
- R13: take_q is high for exactly one cycle per acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_req | input | 1 | Non-maskable request (edge plus held level) |
| line_req | input | 3 | Maskable requests, index 2 highest |
| cmd_ie_set | input | 1 | Enable command strobe |
| cmd_ie_clr | input | 1 | Disable command strobe |
| cmd_mask_wr | input | 1 | Mask-write command strobe |
| mask_wdata | input | 3 | New mask bits, 1 = masked |
| mask_clr_edges | input | 1 | With cmd_mask_wr, discards held edges |
| cmd_status_rd | input | 1 | Status-read command strobe |
| status_q | output | 8 | Captured status word |
| sw_rst_req | input | 1 | Software restart request |
| sw_rst_num | input | 3 | Restart number 0 to 7 |
| take_q | output | 1 | One-cycle acceptance pulse |
| vector_q | output | 16 | Call address, valid while take_q is high |

## Verification
The results arrive at different times after a stimulus. A middle or bottom level is taken at the first clock edge after it is driven. The top-line edge and the non-maskable input need two edges. Enable, disable and mask writes change acceptance only from the edge after the command. A status read is visible one edge after its strobe. The bench drives every stimulus on a falling edge and samples at the falling edge that follows the counted number of rising edges, so each check reads a value that has settled. It also checks the cycle just before and the cycle just after each expected pulse.

// File: rtl/ipu_pkg.sv
// Shared helpers for the interrupt request unit.
// Assumes vector addresses are computed as plain integers and then sized by the caller.
package ipu_pkg;

    // Restart slot n sits at n times the slot size.
    function automatic int restart_addr(input int num, input int slot_bytes);
        return num * slot_bytes;
    endfunction

    // Maskable line i sits i+1 slots above the non-maskable vector.
    function automatic int line_addr(input int base, input int slot_bytes, input int line);
        return base + slot_bytes * (line + 1);
    endfunction

endpackage

// File: rtl/irq_nmi_qual.sv
// Qualifies the non-maskable request: it arms on a low-to-high change and
// fires when the level is still high at the next sample.
// Assumes the request is synchronous to clk. Firing also disarms the qualifier,
// so a held level produces a single acceptance.
module irq_nmi_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic fire
);
    logic prev_q;
    logic armed_q;

    assign fire = armed_q & level;

    // Track the previous level and the armed state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            prev_q  <= level;
            armed_q <= (armed_q | (level & ~prev_q)) & level & ~fire;
        end
    end
endmodule

// File: rtl/irq_edge_hold.sv
// Holds a rising edge of one request line until it is cleared.
// Assumes clear covers both a service of the line and a software discard,
// and that clear wins over a new edge at the same clock edge.
module irq_edge_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic clear,
    output logic pend
);
    logic prev_q;
    logic pend_q;

    assign pend = pend_q;

    // Record a low-to-high change and keep it until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= level;
            pend_q <= (pend_q | (level & ~prev_q)) & ~clear;
        end
    end
endmodule

// File: rtl/irq_prio_pick.sv
// Fixed-priority selector: the highest set index wins.
// Assumes at most one winner is needed per cycle. The index is meaningless when any is low.
module irq_prio_pick #(
    parameter int N     = 3,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // Scan upward so that later (higher) indices override earlier ones.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_prio_unit.sv
// Interrupt request unit: qualifies one non-maskable and NUM_LINES maskable
// requests, arbitrates them by fixed priority, and maps software restart numbers
// to slot addresses. Emits a one-cycle take pulse with the call vector.
// Assumes all inputs are synchronous to clk and commands are single-cycle strobes.
module irq_prio_unit
    import ipu_pkg::*;
#(
    parameter int                  NUM_LINES  = 3,
    parameter logic [NUM_LINES-1:0] EDGE_LINES = 3'b100,
    parameter int                  VEC_W      = 16,
    parameter int                  SLOT_BYTES = 8,
    parameter int                  NMI_VEC    = 'h24,
    parameter int                  RST_NUM_W  = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   nmi_req,
    input  logic [NUM_LINES-1:0]   line_req,
    input  logic                   cmd_ie_set,
    input  logic                   cmd_ie_clr,
    input  logic                   cmd_mask_wr,
    input  logic [NUM_LINES-1:0]   mask_wdata,
    input  logic                   mask_clr_edges,
    input  logic                   cmd_status_rd,
    output logic [2*NUM_LINES+1:0] status_q,
    input  logic                   sw_rst_req,
    input  logic [RST_NUM_W-1:0]   sw_rst_num,
    output logic                   take_q,
    output logic [VEC_W-1:0]       vector_q
);
    localparam int IDX_W  = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
    localparam int STAT_W = 2 * NUM_LINES + 2;

    logic                 ie_q;
    logic [NUM_LINES-1:0] mask_q;
    logic [NUM_LINES-1:0] raw_pend;
    logic [NUM_LINES-1:0] eligible;
    logic [NUM_LINES-1:0] line_svc;
    logic                 any_line;
    logic [IDX_W-1:0]     win_idx;
    logic                 nmi_fire;
    logic                 mask_fire;
    logic                 hw_fire;
    logic                 edge_discard;
    logic [VEC_W-1:0]     vec_d;

    // Non-maskable qualification.
    irq_nmi_qual u_nmi (
        .clk   (clk),
        .rst_n (rst_n),
        .level (nmi_req),
        .fire  (nmi_fire)
    );

    assign edge_discard = cmd_mask_wr & mask_clr_edges;

    // Per-line capture: edge-held or plain level, chosen by EDGE_LINES.
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        if (EDGE_LINES[i]) begin : g_edge
            irq_edge_hold u_hold (
                .clk   (clk),
                .rst_n (rst_n),
                .level (line_req[i]),
                .clear (line_svc[i] | edge_discard),
                .pend  (raw_pend[i])
            );
        end else begin : g_level
            assign raw_pend[i] = line_req[i];
        end
        assign line_svc[i] = mask_fire && (win_idx == IDX_W'(i));
    end

    assign eligible = raw_pend & ~mask_q;

    irq_prio_pick #(
        .N     (NUM_LINES),
        .IDX_W (IDX_W)
    ) u_pick (
        .req (eligible),
        .any (any_line),
        .idx (win_idx)
    );

    assign mask_fire = ie_q && any_line && !nmi_fire;
    assign hw_fire   = nmi_fire || mask_fire;

    // Choose the vector for whichever source is accepted this cycle.
    always_comb begin
        if (nmi_fire) begin
            vec_d = VEC_W'(NMI_VEC);
        end else if (mask_fire) begin
            vec_d = VEC_W'(line_addr(NMI_VEC, SLOT_BYTES, int'(win_idx)));
        end else begin
            vec_d = VEC_W'(restart_addr(int'(sw_rst_num), SLOT_BYTES));
        end
    end

    // Enable flag: an acceptance clears it, then disable, then enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q <= 1'b0;
        end else if (hw_fire || cmd_ie_clr) begin
            ie_q <= 1'b0;
        end else if (cmd_ie_set) begin
            ie_q <= 1'b1;
        end
    end

    // Mask bits: all masked out of reset, loaded by the mask-write command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (cmd_mask_wr) begin
            mask_q <= mask_wdata;
        end
    end

    // Status capture on a read command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else if (cmd_status_rd) begin
            status_q <= STAT_W'({nmi_req, raw_pend, ie_q, mask_q});
        end
    end

    // Take pulse and vector; the vector holds between acceptances.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_q   <= 1'b0;
            vector_q <= '0;
        end else begin
            take_q <= hw_fire || sw_rst_req;
            if (hw_fire || sw_rst_req) begin
                vector_q <= vec_d;
            end
        end
    end
endmodule

// File: rtl/irq_prio_unit_chk.sv
// Property checker for the interrupt request unit, attached by bind.
// Assumes the enable flag is observable as an internal signal of the top.
module irq_prio_unit_chk #(
    parameter int NUM_LINES = 3,
    parameter int VEC_W     = 16,
    parameter int NMI_VEC   = 'h24
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   nmi_req,
    input logic                   take_q,
    input logic [VEC_W-1:0]       vector_q,
    input logic                   ie_q,
    input logic                   cmd_status_rd,
    input logic [2*NUM_LINES+1:0] status_q
);
    logic is_nmi;
    logic is_mask;

    assign is_nmi  = take_q && (vector_q == VEC_W'(NMI_VEC));
    assign is_mask = take_q && vector_q[2] && !is_nmi;

    // Every emitted vector lies on a four-byte boundary below 64.
    assert_vec_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
        take_q |-> ((vector_q >> 6) == '0) && (vector_q[1:0] == 2'b00));

    // A non-maskable take needs the level high at both qualifying samples.
    assert_nmi_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        is_nmi |-> ($past(nmi_req) && $past(nmi_req, 2)));

    // A maskable take needs the enable flag set at the deciding edge.
    assert_mask_needs_ie_R5: assert property (@(posedge clk) disable iff (!rst_n)
        is_mask |-> $past(ie_q));

    // Any hardware take leaves the enable flag clear.
    assert_take_clears_ie_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (take_q && vector_q[2]) |-> !ie_q);

    // Two maskable takes never occur in consecutive cycles.
    assert_single_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        is_mask |=> !is_mask);

    // The status enable bit reports the flag from before the read edge.
    assert_status_ie_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd_status_rd) |-> (status_q[NUM_LINES] == $past(ie_q)));
endmodule

bind irq_prio_unit irq_prio_unit_chk #(
    .NUM_LINES (NUM_LINES),
    .VEC_W     (VEC_W),
    .NMI_VEC   (NMI_VEC)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .nmi_req       (nmi_req),
    .take_q        (take_q),
    .vector_q      (vector_q),
    .ie_q          (ie_q),
    .cmd_status_rd (cmd_status_rd),
    .status_q      (status_q)
);

// File: tb/irq_prio_unit_test.sv
// Self-checking bench: drives on falling edges, samples on falling edges.
module irq_prio_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi_req = 1'b0;
    logic [2:0]  line_req = '0;
    logic        cmd_ie_set = 1'b0;
    logic        cmd_ie_clr = 1'b0;
    logic        cmd_mask_wr = 1'b0;
    logic [2:0]  mask_wdata = '0;
    logic        mask_clr_edges = 1'b0;
    logic        cmd_status_rd = 1'b0;
    logic [7:0]  status_q;
    logic        sw_rst_req = 1'b0;
    logic [2:0]  sw_rst_num = '0;
    logic        take_q;
    logic [15:0] vector_q;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    irq_prio_unit uut (
        .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .line_req(line_req),
        .cmd_ie_set(cmd_ie_set), .cmd_ie_clr(cmd_ie_clr),
        .cmd_mask_wr(cmd_mask_wr), .mask_wdata(mask_wdata),
        .mask_clr_edges(mask_clr_edges), .cmd_status_rd(cmd_status_rd),
        .status_q(status_q), .sw_rst_req(sw_rst_req), .sw_rst_num(sw_rst_num),
        .take_q(take_q), .vector_q(vector_q)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk_take(input logic et, input logic [15:0] ev, input string tag);
        total++;
        if (take_q !== et || (et && vector_q !== ev)) begin
            bad++;
            $display("FAIL %s: take=%0b vec=%h expected take=%0b vec=%h",
                     tag, take_q, vector_q, et, ev);
        end
    endtask

    task automatic chk_status(input logic [7:0] es, input string tag);
        cmd_status_rd = 1'b1;
        tick();
        cmd_status_rd = 1'b0;
        total++;
        if (status_q !== es) begin
            bad++;
            $display("FAIL %s: status=%h expected %h", tag, status_q, es);
        end
    endtask

    task automatic set_mask(input logic [2:0] m, input logic clr);
        cmd_mask_wr = 1'b1; mask_wdata = m; mask_clr_edges = clr;
        tick();
        cmd_mask_wr = 1'b0; mask_clr_edges = 1'b0;
    endtask

    task automatic do_ei();
        cmd_ie_set = 1'b1; tick(); cmd_ie_set = 1'b0;
    endtask

    task automatic do_di();
        cmd_ie_clr = 1'b1; tick(); cmd_ie_clr = 1'b0;
    endtask

    // Expected {take, vector} for a set of eligible maskable lines.
    function automatic logic [16:0] expect_pick(input logic [2:0] p);
        for (int i = 2; i >= 0; i--) begin
            if (p[i]) return {1'b1, 16'(36 + 8 * (i + 1))};
        end
        return 17'd0;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [16:0] e;
        repeat (3) tick();
        rst_n = 1'b1;
        chk_take(1'b0, 16'h0, "R1 take after reset");
        chk_status(8'h07, "R1 status after reset");

        // Software restart sweep.
        for (int n = 0; n < 8; n++) begin
            sw_rst_req = 1'b1; sw_rst_num = 3'(n);
            tick();
            sw_rst_req = 1'b0;
            chk_take(1'b1, 16'(n * 8), "R12 restart vector");
            tick();
            chk_take(1'b0, 16'h0, "R13 restart single pulse");
        end

        // Enable timing and clearing on take.
        set_mask(3'b000, 1'b1);
        line_req = 3'b001;
        tick();
        chk_take(1'b0, 16'h0, "R5 disabled bottom line");
        do_ei();
        chk_take(1'b0, 16'h0, "R6 enable not yet active");
        tick();
        chk_take(1'b1, 16'h002C, "R6 bottom taken after enable");
        tick();
        chk_take(1'b0, 16'h0, "R7 held level not retaken");
        line_req = 3'b011;
        chk_status(8'h30, "R11 raw levels in status");
        line_req = 3'b000;

        // Disable.
        do_ei();
        do_di();
        line_req = 3'b001;
        tick();
        chk_take(1'b0, 16'h0, "R6 disabled after clear command");
        tick();
        chk_take(1'b0, 16'h0, "R6 still disabled");
        line_req = 3'b000;

        // Level line removed before enable.
        line_req = 3'b010;
        tick();
        line_req = 3'b000;
        tick();
        do_ei();
        tick();
        chk_take(1'b0, 16'h0, "R9 removed level leaves no trace");
        do_di();

        // Mask write timing.
        set_mask(3'b111, 1'b1);
        do_ei();
        line_req = 3'b001;
        tick();
        chk_take(1'b0, 16'h0, "R5 masked bottom line");
        set_mask(3'b000, 1'b0);
        chk_take(1'b0, 16'h0, "R10 old mask at write edge");
        tick();
        chk_take(1'b1, 16'h002C, "R10 new mask next edge");
        line_req = 3'b000;
        tick();

        // Priority sweep over all request combinations.
        for (int c = 0; c < 8; c++) begin
            set_mask(3'b000, 1'b1);
            line_req = {c[2], 2'b00};
            tick();
            line_req = 3'(c);
            do_ei();
            chk_take(1'b0, 16'h0, "R6 sweep enable edge");
            tick();
            e = expect_pick(3'(c));
            chk_take(e[16], e[15:0], "R4 priority sweep");
            line_req = 3'b000;
            set_mask(3'b000, 1'b1);
            do_di();
        end

        // Mask sweep with all lines requesting.
        for (int m = 0; m < 8; m++) begin
            set_mask(3'(m), 1'b1);
            line_req = 3'b100;
            tick();
            line_req = 3'b111;
            do_ei();
            chk_take(1'b0, 16'h0, "R6 mask sweep enable edge");
            tick();
            e = expect_pick(~3'(m));
            chk_take(e[16], e[15:0], "R5 mask sweep");
            tick();
            chk_take(1'b0, 16'h0, "R7 no second take");
            chk_status({1'b0, m[2], 2'b11, (m == 7), 3'(m)}, "R8 edge kept while masked");
            line_req = 3'b000;
            set_mask(3'(m), 1'b1);
            do_di();
        end

        // Edge held after line drops, then discarded.
        set_mask(3'b111, 1'b1);
        line_req = 3'b100;
        tick();
        line_req = 3'b000;
        tick();
        chk_status(8'h47, "R8 edge held after drop");
        set_mask(3'b111, 1'b1);
        chk_status(8'h07, "R8 edge discarded by mask write");

        // Non-maskable qualification.
        nmi_req = 1'b1;
        tick();
        chk_take(1'b0, 16'h0, "R2 first sample arms only");
        tick();
        chk_take(1'b1, 16'h0024, "R2 held level taken");
        tick();
        chk_take(1'b0, 16'h0, "R13 held level taken once");
        nmi_req = 1'b0;
        tick();
        nmi_req = 1'b1;
        tick();
        chk_take(1'b0, 16'h0, "R2 glitch first sample");
        nmi_req = 1'b0;
        tick();
        chk_take(1'b0, 16'h0, "R2 glitch rejected");
        tick();
        chk_take(1'b0, 16'h0, "R2 glitch stays rejected");

        // Non-maskable beats a maskable line at the same edge.
        set_mask(3'b000, 1'b1);
        do_ei();
        nmi_req = 1'b1; line_req = 3'b100;
        tick();
        chk_take(1'b0, 16'h0, "R3 both arming");
        tick();
        chk_take(1'b1, 16'h0024, "R3 non-maskable wins");
        tick();
        chk_take(1'b0, 16'h0, "R7 take cleared enable");
        chk_status(8'hC0, "R11 status fields");
        do_ei();
        tick();
        chk_take(1'b1, 16'h003C, "R8 held edge serviced later");
        nmi_req = 1'b0; line_req = 3'b000;
        tick();

        // Hardware wins over restart; restart leaves the flag alone.
        do_ei();
        line_req = 3'b010; sw_rst_req = 1'b1; sw_rst_num = 3'd3;
        tick();
        chk_take(1'b1, 16'h0034, "R12 hardware beats restart");
        sw_rst_req = 1'b0; line_req = 3'b000;
        tick();
        chk_take(1'b0, 16'h0, "R12 restart dropped");
        do_ei();
        sw_rst_req = 1'b1; sw_rst_num = 3'd6;
        tick();
        sw_rst_req = 1'b0;
        chk_take(1'b1, 16'h0030, "R12 restart vector");
        chk_status(8'h08, "R12 enable unchanged by restart");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule